// File: doc/BRIEF.md
# Virtual Interrupt Flag Controller

This block holds the interrupt-masking flags of a processor core that can run legacy programs in a compatibility mode under a supervising monitor. It keeps three state bits: the real interrupt-enable flag, a shadow (virtual) interrupt flag that a guest program may freely toggle, and a virtual pending flag that only the monitor writes. Every cycle it receives a decoded instruction class and steers it by mode. The instruction can act on the real flag, act on the shadow flag, or raise a trap to the monitor.

The mode comes from three inputs: the mode-extension enable, the 2-bit I/O privilege level, and the compatibility-mode indicator. Outside compatibility mode, and inside it at privilege level 3, the flag instructions work on the real flag. Inside compatibility mode below level 3 with the extension enabled, they work on the shadow flag and never trap, with one exception. A set-interrupt instruction issued while an interrupt is pending traps instead. With the extension disabled they all trap. Hardware interrupts are accepted only through the real flag. The block also produces the flags word and the image that a push-flags instruction would store.

Top module: `vif_ctrl`

## Requirements
- R1: A synchronous reset clears the real flag, the shadow flag, the pending flag and the trap output.
- R2: `flags_word` shows the real flag at bit 9, the shadow flag at bit 19 and the pending flag at bit 20, with all other bits 0.
- R3: In virtual mode (compatibility mode, privilege level below 3, extension enabled), clear-interrupt (op 1) writes 0 and set-interrupt (op 2) writes 1 to the shadow flag at the next edge, and the real flag is unchanged.
- R4: `irq_accept` equals `irq_req` AND the real flag, in the same cycle.
- R5: In trap mode (compatibility mode, privilege level below 3, extension disabled), ops 1 to 4 raise `trap_mon` in the next cycle and change no flag.
- R6: In virtual mode, push-flags (op 3), pop-flags (op 4) and clear-interrupt never raise `trap_mon`.
- R7: In virtual mode, set-interrupt while the pending flag is 1 raises `trap_mon` in the next cycle and leaves the shadow flag unchanged.
- R8: Outside compatibility mode, or in it at privilege level 3, clear, set and pop (from bit 9 of `pop_word`) act on the real flag without a trap, and the shadow flag is unchanged.
- R9: In virtual mode, `push_word` equals `flags_word` with bit 9 replaced by the shadow flag. In every other mode it equals `flags_word`.
- R10: In virtual mode, pop-flags loads bit 9 of `pop_word` into the shadow flag and changes neither the real flag nor the pending flag.
- R11: The pending flag changes only through `mon_pend_we`, which loads `mon_pend_val` at the edge.
- R12: `trap_mon` is a one-cycle pulse per trapping instruction. It is 0 in a cycle that follows a non-trapping op.
- R13: Op codes 0, 5, 6 and 7 change no flag and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ext_en | input | 1 | Mode-extension enable |
| iopl | input | 2 | I/O privilege level |
| compat_mode | input | 1 | Compatibility (legacy) mode indicator |
| op_code | input | 3 | Decoded instruction class: 0 none, 1 clear, 2 set, 3 push, 4 pop |
| pop_word | input | 32 | Flags word being popped |
| irq_req | input | 1 | Maskable interrupt request |
| mon_pend_we | input | 1 | Monitor write strobe for the pending flag |
| mon_pend_val | input | 1 | Value written to the pending flag |
| flags_word | output | 32 | Current flags word |
| push_word | output | 32 | Image a push-flags instruction stores |
| irq_accept | output | 1 | Interrupt accepted this cycle |
| trap_mon | output | 1 | Trap to monitor, one-cycle pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit flags word, the real flag at bit 9, the shadow flag at 19, the pending flag at 20, and a 2-bit privilege field. With this build every privilege level, including the top level 3 that selects direct handling, is reachable from random stimulus. Compatibility mode is biased on, so virtual, trap and direct modes all occur often. Monitor writes are mixed in, so set-interrupt meets both values of the pending flag. The unused op codes 5 to 7 are drawn as well.

// File: rtl/vif_pkg.sv
package vif_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CLR  = 3'd1,
    OP_SET  = 3'd2,
    OP_PUSH = 3'd3,
    OP_POP  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    M_NATIVE = 2'd0,
    M_DIRECT = 2'd1,
    M_VIRT   = 2'd2,
    M_TRAP   = 2'd3
  } mode_e;

  // Mode selection from the three steering inputs.
  function automatic mode_e classify(logic ext, logic pl_top, logic compat);
    if (!compat)     return M_NATIVE;
    else if (pl_top) return M_DIRECT;
    else if (ext)    return M_VIRT;
    else             return M_TRAP;
  endfunction

  // True for the four flag-touching instruction classes.
  function automatic logic is_flag_op(logic [2:0] op);
    return (op == OP_CLR) || (op == OP_SET) || (op == OP_PUSH) || (op == OP_POP);
  endfunction

endpackage

// File: rtl/vif_mode_dec.sv
module vif_mode_dec
  import vif_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            ext_en,
  input  logic [PL_W-1:0] iopl,
  input  logic            compat_mode,
  output mode_e           mode
);
  logic pl_top;
  assign pl_top = &iopl;
  assign mode   = classify(ext_en, pl_top, compat_mode);
endmodule

// File: rtl/vif_flag_regs.sv
module vif_flag_regs
  import vif_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mode_e      mode,
  input  logic [2:0] op,
  input  logic       pop_ie,
  input  logic       mon_we,
  input  logic       mon_val,
  output logic       if_q,
  output logic       vif_q,
  output logic       vip_q,
  output logic       trap_q
);
  logic if_wr, if_nx, vif_wr, vif_nx, trap_now;

  always_comb begin
    if_wr    = 1'b0;
    if_nx    = if_q;
    vif_wr   = 1'b0;
    vif_nx   = vif_q;
    trap_now = 1'b0;
    unique case (mode)
      M_NATIVE, M_DIRECT: begin
        if (op == OP_CLR) begin
          if_wr = 1'b1; if_nx = 1'b0;
        end else if (op == OP_SET) begin
          if_wr = 1'b1; if_nx = 1'b1;
        end else if (op == OP_POP) begin
          if_wr = 1'b1; if_nx = pop_ie;
        end
      end
      M_VIRT: begin
        if (op == OP_CLR) begin
          vif_wr = 1'b1; vif_nx = 1'b0;
        end else if (op == OP_SET) begin
          if (vip_q) trap_now = 1'b1;
          else begin
            vif_wr = 1'b1; vif_nx = 1'b1;
          end
        end else if (op == OP_POP) begin
          vif_wr = 1'b1; vif_nx = pop_ie;
        end
      end
      M_TRAP: trap_now = is_flag_op(op);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_q   <= 1'b0;
      vif_q  <= 1'b0;
      vip_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= trap_now;
      if (if_wr)  if_q  <= if_nx;
      if (vif_wr) vif_q <= vif_nx;
      if (mon_we) vip_q <= mon_val;
    end
  end

  p_if_hold_virt_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == M_VIRT && (op == OP_CLR || op == OP_SET)) |=> $stable(if_q));

  p_trap_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TRAP && is_flag_op(op)) |=> (trap_q && $stable(if_q) && $stable(vif_q)));

  p_sti_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == M_VIRT && op == OP_SET && vip_q) |=> (trap_q && $stable(vif_q)));

  p_pop_virt_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == M_VIRT && op == OP_POP) |=> (vif_q == $past(pop_ie) && $stable(if_q)));

  p_vip_mon_only_r11: assert property (@(posedge clk) disable iff (rst)
    !mon_we |=> $stable(vip_q));

  p_no_trap_virt_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == M_VIRT && op != OP_SET) |=> !trap_q);
endmodule

// File: rtl/vif_word_pack.sv
module vif_word_pack
  import vif_pkg::*;
#(
  parameter int FLAG_W    = 32,
  parameter int IE_BIT    = 9,
  parameter int VIE_BIT   = 19,
  parameter int VPEND_BIT = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode,
  input  logic              if_q,
  input  logic              vif_q,
  input  logic              vip_q,
  output logic [FLAG_W-1:0] flags_word,
  output logic [FLAG_W-1:0] push_word
);
  always_comb begin
    for (int i = 0; i < FLAG_W; i++) begin
      if (i == IE_BIT)         flags_word[i] = if_q;
      else if (i == VIE_BIT)   flags_word[i] = vif_q;
      else if (i == VPEND_BIT) flags_word[i] = vip_q;
      else                     flags_word[i] = 1'b0;
    end
  end

  always_comb begin
    push_word = flags_word;
    if (mode == M_VIRT) push_word[IE_BIT] = vif_q;
  end

  p_push_image_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == M_VIRT) |-> (push_word[IE_BIT] == flags_word[VIE_BIT]));
endmodule

// File: rtl/vif_ctrl.sv
module vif_ctrl
  import vif_pkg::*;
#(
  parameter int FLAG_W    = 32,
  parameter int PL_W      = 2,
  parameter int IE_BIT    = 9,
  parameter int VIE_BIT   = 19,
  parameter int VPEND_BIT = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic [PL_W-1:0]   iopl,
  input  logic              compat_mode,
  input  logic [2:0]        op_code,
  input  logic [FLAG_W-1:0] pop_word,
  input  logic              irq_req,
  input  logic              mon_pend_we,
  input  logic              mon_pend_val,
  output logic [FLAG_W-1:0] flags_word,
  output logic [FLAG_W-1:0] push_word,
  output logic              irq_accept,
  output logic              trap_mon
);
  mode_e mode;
  logic  if_q, vif_q, vip_q;

  vif_mode_dec #(.PL_W(PL_W)) u_dec (
    .ext_en      (ext_en),
    .iopl        (iopl),
    .compat_mode (compat_mode),
    .mode        (mode)
  );

  vif_flag_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .op      (op_code),
    .pop_ie  (pop_word[IE_BIT]),
    .mon_we  (mon_pend_we),
    .mon_val (mon_pend_val),
    .if_q    (if_q),
    .vif_q   (vif_q),
    .vip_q   (vip_q),
    .trap_q  (trap_mon)
  );

  vif_word_pack #(
    .FLAG_W(FLAG_W), .IE_BIT(IE_BIT), .VIE_BIT(VIE_BIT), .VPEND_BIT(VPEND_BIT)
  ) u_pack (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .if_q       (if_q),
    .vif_q      (vif_q),
    .vip_q      (vip_q),
    .flags_word (flags_word),
    .push_word  (push_word)
  );

  assign irq_accept = irq_req & if_q;

  p_accept_gate_r4: assert property (@(posedge clk) disable iff (rst)
    irq_accept |-> (irq_req && flags_word[IE_BIT]));

  p_trap_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (!is_flag_op(op_code)) |=> !trap_mon);
endmodule

// File: tb/vif_ctrl_tb.sv
module vif_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_en = 1'b0, compat_mode = 1'b0, irq_req = 1'b0;
  logic        mon_pend_we = 1'b0, mon_pend_val = 1'b0;
  logic [1:0]  iopl = 2'd0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] pop_word = 32'd0;
  logic [31:0] flags_word, push_word;
  logic        irq_accept, trap_mon;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic m_if = 0, m_vif = 0, m_vip = 0, m_trap = 0;

  always #5 clk = ~clk;

  vif_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_en(ext_en), .iopl(iopl), .compat_mode(compat_mode),
    .op_code(op_code), .pop_word(pop_word), .irq_req(irq_req),
    .mon_pend_we(mon_pend_we), .mon_pend_val(mon_pend_val),
    .flags_word(flags_word), .push_word(push_word),
    .irq_accept(irq_accept), .trap_mon(trap_mon)
  );

  // 0 native, 1 direct, 2 virtual, 3 trap
  function automatic int mode_of(logic e, logic [1:0] p, logic c);
    if (!c) return 0;
    if (p == 2'd3) return 1;
    return e ? 2 : 3;
  endfunction

  function automatic logic [31:0] word_of(logic f_if, logic f_vif, logic f_vip);
    logic [31:0] w = 32'd0;
    w[9] = f_if; w[19] = f_vif; w[20] = f_vip;
    return w;
  endfunction

  function automatic string tag_of(int md, logic [2:0] op, logic vip);
    if (op == 0 || op > 4) return "R13";
    if (md == 3) return "R5";
    if (md != 2) return "R8";
    if (op == 2 && vip) return "R7";
    if (op == 4) return "R10";
    if (op == 3) return "R6";
    return "R3";
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic e, logic [1:0] p, logic c, logic [2:0] op,
                      logic [31:0] pw, logic irq, logic mwe, logic mval);
    int md;
    logic [31:0] exp_push;
    logic t;
    string tg;
    ext_en = e; iopl = p; compat_mode = c; op_code = op; pop_word = pw;
    irq_req = irq; mon_pend_we = mwe; mon_pend_val = mval;
    md = mode_of(e, p, c);
    #1;
    chk(irq_accept == (irq & m_if), "R4", {31'd0, irq_accept}, {31'd0, irq & m_if});
    exp_push = word_of(m_if, m_vif, m_vip);
    if (md == 2) exp_push[9] = m_vif;
    chk(push_word == exp_push, "R9", push_word, exp_push);
    tg = tag_of(md, op, m_vip);
    @(posedge clk);
    t = 1'b0;
    if (op >= 1 && op <= 4) begin
      case (md)
        0, 1: begin
          if (op == 1) m_if = 1'b0;
          if (op == 2) m_if = 1'b1;
          if (op == 4) m_if = pw[9];
        end
        2: begin
          if (op == 1) m_vif = 1'b0;
          if (op == 2) begin
            if (m_vip) t = 1'b1; else m_vif = 1'b1;
          end
          if (op == 4) m_vif = pw[9];
        end
        default: t = 1'b1;
      endcase
    end
    if (mwe) m_vip = mval;
    @(negedge clk);
    chk(flags_word == word_of(m_if, m_vif, m_vip), mwe ? "R11" : tg,
        flags_word, word_of(m_if, m_vif, m_vip));
    chk(trap_mon == t, t ? tg : (m_trap ? "R12" : tg), {31'd0, trap_mon}, {31'd0, t});
    m_trap = t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(flags_word == 32'd0, "R1", flags_word, 32'd0);
    chk(trap_mon == 1'b0, "R1", {31'd0, trap_mon}, 32'd0);
    // R2 bit positions via direct mode and monitor write
    step(1, 2'd3, 1, 3'd2, 0, 1, 1, 1);           // IF=1, VIP=1
    chk(flags_word == 32'h0010_0200, "R2", flags_word, 32'h0010_0200);
    // R7 set-interrupt in virtual mode with pending
    step(1, 2'd0, 1, 3'd2, 0, 0, 0, 0);
    chk(flags_word[19] == 1'b0, "R7", flags_word, 32'd0);
    // R12 pulse ends
    step(1, 2'd0, 1, 3'd0, 0, 0, 0, 0);
    // R11 clear pending, then set-interrupt succeeds (R3)
    step(1, 2'd1, 1, 3'd0, 0, 0, 1, 0);
    step(1, 2'd1, 1, 3'd2, 0, 1, 0, 0);
    chk(flags_word == 32'h0008_0200, "R3", flags_word, 32'h0008_0200);
    // R10 pop loads shadow, R9 push image
    step(1, 2'd2, 1, 3'd4, 32'h0000_0000, 0, 0, 0);
    step(1, 2'd2, 1, 3'd3, 0, 0, 0, 0);
    // R5 trap mode
    step(0, 2'd0, 1, 3'd1, 0, 0, 0, 0);
    // R13 unused op
    step(1, 2'd0, 0, 3'd6, 32'hFFFF_FFFF, 1, 0, 0);
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      if (($urandom % 8) == 0) op = 3'($urandom_range(5, 7));
      step(1'($urandom), 2'($urandom), ($urandom % 4) != 0, op,
           $urandom, 1'($urandom), ($urandom % 8) == 0, 1'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule